// File: doc/BRIEF.md
# Two-Channel PWM DAC with Rate-Multiplier Refinement

This block turns a digital code into a pulse train whose average level, after an external RC low-pass filter, follows that code. Each of its two channels combines a 6-bit pulse-width modulator running on a 64-clock period with a 4-bit rate multiplier. The rate multiplier lengthens the high time of selected periods by one clock. It picks those periods from a 16-period frame, so the channel's average duty has 10 bits of resolution: 1024 clocks per frame, with 16·duty + rate of them high.

Software programs the block through an 8-bit write port. There is one control byte per channel, carrying the duty and an output-invert flag, and one shared byte that holds both channels' 4-bit rate fields. Written values sit in a staging stage and are moved into the active settings only at the start of the next PWM period, so a write never cuts a pulse short. Each channel drives one dedicated output pin.

Top module: `pwm_rate_dac`

## Requirements
- R1: After reset every setting is zero and both outputs stay low.
- R2: A PWM period is 64 clocks. With rate 0 and invert clear, each period holds exactly `duty` consecutive high clocks followed by `64 - duty` low clocks.
- R3: For duty values 1 to 62, within any 16 consecutive periods exactly `rate` periods are high for `duty + 1` clocks and the rest for `duty` clocks.
- R4: When the rate is a power of two 2^k, the lengthened periods are spaced exactly 16/2^k periods apart, not grouped together.
- R5: Setting bit 7 of a channel's control byte inverts that channel's output, so its high count becomes the low count.
- R6: Write address map: address 0 is channel 0 control, address 1 is channel 1 control (bits 5:0 duty, bit 7 invert, bit 6 has no effect), and address 2 holds the rates (bits 3:0 channel 0, bits 7:4 channel 1). Writes to address 3 change nothing.
- R7: A write takes effect only at the start of the next PWM period. The period in progress completes with its old settings.
- R8: Over any 1024 consecutive clocks in steady state, a channel is high for exactly 16·duty + rate clocks, or 1024 minus that when inverted. This includes duty 0 and duty 63.
- R9: The 4-bit frame position advances by one exactly when the period counter wraps, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the settings port |
| wr_addr | input | 2 | Setting address |
| wr_data | input | 8 | Setting value |
| dac_out | output | 2 | Pulse output, one bit per channel |

## Verification
On every cycle, the assertions check four things: the frame position steps only on a period wrap; active settings stay frozen away from period starts; no frame position belongs to more than one rate bit; and an all-zero channel keeps its pin low. The bench scenarios cover what only shows over long windows. Measured run lengths give the 64-clock period and the count and even spacing of lengthened periods. The 1024-clock high totals check the 10-bit average, with inversion, random codes and the duty 0 and 63 extremes. A write issued mid-period is checked for being deferred to the next period, and writes to the spare address for having no effect.

// File: rtl/pwm_rate_pkg.sv
package pwm_rate_pkg;

  localparam int unsigned PR_NUM_CH  = 2;
  localparam int unsigned PR_DUTY_W  = 6;
  localparam int unsigned PR_RATE_W  = 4;
  localparam int unsigned PR_DATA_W  = 8;
  localparam int unsigned PR_ADDR_W  = $clog2(PR_NUM_CH + 1);

  // Settings one channel runs with during a period
  typedef struct packed {
    logic                 invert;
    logic [PR_DUTY_W-1:0] duty;
    logic [PR_RATE_W-1:0] rate;
  } chan_cfg_t;

endpackage

// File: rtl/pwm_rate_timebase.sv
module pwm_rate_timebase #(
  parameter int unsigned CNT_W   = pwm_rate_pkg::PR_DUTY_W,
  parameter int unsigned FRAME_W = pwm_rate_pkg::PR_RATE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [CNT_W-1:0]   cnt,
  output logic [FRAME_W-1:0] frame,
  output logic               period_last
);

  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic               frame_en;

  assign period_last = (cnt_q == {CNT_W{1'b1}});
  assign frame_en    = period_last;

  always_comb begin
    cnt_d   = cnt_q + 1'b1;
    frame_d = frame_q;
    if (frame_en) begin
      frame_d = frame_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      frame_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      frame_q <= frame_d;
    end
  end

  assign cnt   = cnt_q;
  assign frame = frame_q;

  AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == {CNT_W{1'b1}}) |=> (cnt_q == '0) && (frame_q == FRAME_W'($past(frame_q) + 1'b1))) // R9
    else $error("frame did not advance on wrap");

  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != {CNT_W{1'b1}}) |=> $stable(frame_q)) // R9
    else $error("frame moved mid-period");

endmodule

// File: rtl/pwm_rate_regs.sv
module pwm_rate_regs
  import pwm_rate_pkg::*;
#(
  parameter int unsigned NUM_CH = PR_NUM_CH,
  parameter int unsigned DATA_W = PR_DATA_W,
  parameter int unsigned ADDR_W = PR_ADDR_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic                         period_last,
  output chan_cfg_t [NUM_CH-1:0]       act_cfg
);

  localparam int unsigned RATE_BITS = NUM_CH * PR_RATE_W;
  localparam int unsigned INV_BIT   = DATA_W - 1;

  // Staged control bytes: invert flag and duty per channel
  logic [NUM_CH-1:0]                  inv_q, inv_d;
  logic [NUM_CH-1:0][PR_DUTY_W-1:0]   duty_q, duty_d;
  logic [RATE_BITS-1:0]               rate_q, rate_d;
  chan_cfg_t [NUM_CH-1:0]             act_q, act_d;
  logic                               load_en;

  assign load_en = period_last;

  always_comb begin
    inv_d  = inv_q;
    duty_d = duty_q;
    rate_d = rate_q;
    if (wr_en) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (wr_addr == ADDR_W'(c)) begin
          inv_d[c]  = wr_data[INV_BIT];
          duty_d[c] = wr_data[PR_DUTY_W-1:0];
        end
      end
      if (wr_addr == ADDR_W'(NUM_CH)) begin
        rate_d = wr_data[RATE_BITS-1:0];
      end
    end
  end

  always_comb begin
    act_d = act_q;
    if (load_en) begin
      for (int c = 0; c < NUM_CH; c++) begin
        act_d[c].invert = inv_q[c];
        act_d[c].duty   = duty_q[c];
        act_d[c].rate   = rate_q[c*PR_RATE_W +: PR_RATE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inv_q  <= '0;
      duty_q <= '0;
      rate_q <= '0;
      act_q  <= '0;
    end else begin
      inv_q  <= inv_d;
      duty_q <= duty_d;
      rate_q <= rate_d;
      act_q  <= act_d;
    end
  end

  assign act_cfg = act_q;

  AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    !period_last |=> $stable(act_q)) // R7
    else $error("active settings changed mid-period");

endmodule

// File: rtl/pwm_rate_chan.sv
module pwm_rate_chan
  import pwm_rate_pkg::*;
#(
  parameter int unsigned CNT_W  = PR_DUTY_W,
  parameter int unsigned RATE_W = PR_RATE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  chan_cfg_t         cfg,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [RATE_W-1:0] frame,
  output logic              pin
);

  // owner[b] marks frame positions that rate bit b lengthens.
  // Bit b owns 2^b positions; the sets are disjoint and interleaved.
  logic [RATE_W-1:0] owner;
  logic              stretch;
  logic [CNT_W:0]    thresh;
  logic              level;
  logic              pin_q, pin_d;

  for (genvar j = 0; j < RATE_W; j++) begin : g_owner
    if (j == 0) begin : g_lsb
      assign owner[RATE_W-1] = frame[0];
    end else begin : g_upper
      assign owner[RATE_W-1-j] = frame[j] && (frame[j-1:0] == '0);
    end
  end

  assign stretch = |(owner & cfg.rate);
  assign thresh  = {1'b0, cfg.duty} + {{CNT_W{1'b0}}, stretch};
  assign level   = ({1'b0, cnt} < thresh);

  always_comb begin
    pin_d = level ^ cfg.invert;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
    end else begin
      pin_q <= pin_d;
    end
  end

  assign pin = pin_q;

  AST_OWNER_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(owner)) // R3
    else $error("frame position owned by two rate bits");

  AST_OUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.duty == '0 && cfg.rate == '0 && !cfg.invert) |=> !pin_q) // R1
    else $error("idle channel drove high");

endmodule

// File: rtl/pwm_rate_dac.sv
module pwm_rate_dac
  import pwm_rate_pkg::*;
#(
  parameter int unsigned NUM_CH = PR_NUM_CH,
  parameter int unsigned DATA_W = PR_DATA_W,
  parameter int unsigned ADDR_W = PR_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NUM_CH-1:0] dac_out
);

  localparam int unsigned CNT_W   = PR_DUTY_W;
  localparam int unsigned FRAME_W = PR_RATE_W;

  logic [CNT_W-1:0]       cnt;
  logic [FRAME_W-1:0]     frame;
  logic                   period_last;
  chan_cfg_t [NUM_CH-1:0] act_cfg;

  pwm_rate_timebase #(
    .CNT_W   (CNT_W),
    .FRAME_W (FRAME_W)
  ) u_timebase (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt         (cnt),
    .frame       (frame),
    .period_last (period_last)
  );

  pwm_rate_regs #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .period_last (period_last),
    .act_cfg     (act_cfg)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    pwm_rate_chan #(
      .CNT_W  (CNT_W),
      .RATE_W (FRAME_W)
    ) u_chan (
      .clk   (clk),
      .rst_n (rst_n),
      .cfg   (act_cfg[c]),
      .cnt   (cnt),
      .frame (frame),
      .pin   (dac_out[c])
    );
  end

endmodule

// File: tb/tb_pwm_rate_dac.sv
module tb_pwm_rate_dac;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic [1:0] dac_out;

  int n_checks;
  int n_fails;
  bit done;

  pwm_rate_dac dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .dac_out (dac_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int exp_total(int duty, int rate, bit inv);
    int hi;
    hi = 16 * duty + rate;
    return inv ? (1024 - hi) : hi;
  endfunction

  task automatic check(bit ok, string req, int actual, int expected);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic wr(int addr, int data);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = 2'(addr);
    wr_data = 8'(data);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic settle();
    repeat (80) @(negedge clk);
  endtask

  task automatic total_high(output int t0, output int t1);
    t0 = 0;
    t1 = 0;
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk);
      t0 += int'(dac_out[0]);
      t1 += int'(dac_out[1]);
    end
  endtask

  task automatic sync_rise0();
    while (dac_out[0] !== 1'b0) @(negedge clk);
    while (dac_out[0] !== 1'b1) @(negedge clk);
  endtask

  // Measures 16 consecutive periods of channel 0 (invert clear, duty 1..62)
  task automatic runs16(int duty, int rate, string req);
    int hi [16];
    int lo;
    int n_long;
    bit periodic;
    int step;
    sync_rise0();
    for (int p = 0; p < 16; p++) begin
      hi[p] = 0;
      lo    = 0;
      while (dac_out[0] === 1'b1) begin hi[p]++; @(negedge clk); end
      while (dac_out[0] === 1'b0) begin lo++;    @(negedge clk); end
      check(hi[p] + lo == 64, "R2 period length", hi[p] + lo, 64);
      check(hi[p] == duty || hi[p] == duty + 1, "R3 high run", hi[p], duty);
    end
    n_long = 0;
    for (int p = 0; p < 16; p++) n_long += (hi[p] == duty + 1) ? 1 : 0;
    check(n_long == rate, {req, " R3 lengthened count"}, n_long, rate);
    if (rate == 1 || rate == 2 || rate == 4 || rate == 8) begin
      step = 16 / rate;
      periodic = 1'b1;
      for (int p = 0; p < 16; p++) begin
        if (hi[p] != hi[(p + step) % 16]) periodic = 1'b0;
      end
      check(periodic, {req, " R4 even spacing"}, int'(periodic), 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int t0, t1, lo;
    int d0, d1, r0, r1, hi_run;
    bit i0, i1;
    int sum0;
    void'($urandom(32'h00c0ffee));
    done    = 1'b0;
    n_checks = 0;
    n_fails  = 0;
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    repeat (5) @(negedge clk);
    check(dac_out == 2'b00, "R1 output in reset", int'(dac_out), 0);
    rst_n = 1'b1;

    // R1: idle after reset
    total_high(t0, t1);
    check(t0 == 0 && t1 == 0, "R1 idle after reset", t0 + t1, 0);

    // R2: plain PWM, one period shape
    wr(0, 10);
    settle();
    runs16(10, 0, "rate0");

    // R3 / R4: lengthened periods
    wr(0, 20);
    wr(2, 8'h08);
    settle();
    runs16(20, 8, "rate8");
    wr(2, 8'h04); settle(); runs16(20, 4, "rate4");
    wr(2, 8'h02); settle(); runs16(20, 2, "rate2");
    wr(2, 8'h01); settle(); runs16(20, 1, "rate1");
    wr(2, 8'h05); settle(); runs16(20, 5, "rate5");
    wr(0, 62); wr(2, 8'h0F); settle(); runs16(62, 15, "rate15");

    // R7: mid-period write is deferred to the next period
    wr(2, 8'h00);
    wr(0, 10);
    settle();
    sync_rise0();
    hi_run = 0;
    while (dac_out[0] === 1'b1) begin hi_run++; @(negedge clk); end
    check(hi_run == 10, "R7 run before write", hi_run, 10);
    wr(0, 40);
    lo = 2;
    while (dac_out[0] === 1'b0) begin lo++; @(negedge clk); end
    check(lo == 54, "R7 old period finishes low", lo, 54);
    hi_run = 0;
    while (dac_out[0] === 1'b1) begin hi_run++; @(negedge clk); end
    check(hi_run == 40, "R7 new duty next period", hi_run, 40);

    // R8 / R5 directed extremes
    wr(0, 63); wr(1, 8'h80); wr(2, 8'h0F);
    settle();
    total_high(t0, t1);
    check(t0 == exp_total(63, 15, 0), "R8 duty 63 rate 15", t0, exp_total(63, 15, 0));
    check(t1 == exp_total(0, 0, 1), "R5 inverted zero", t1, exp_total(0, 0, 1));
    wr(0, 0); wr(1, 8'hBF); wr(2, 8'hF3);
    settle();
    total_high(t0, t1);
    check(t0 == exp_total(0, 3, 0), "R8 duty 0 rate 3", t0, exp_total(0, 3, 0));
    check(t1 == exp_total(63, 15, 1), "R5 inverted full", t1, exp_total(63, 15, 1));

    // R6 / R8 / R5: random codes, bit 6 randomized
    for (int k = 0; k < 8; k++) begin
      d0 = int'($urandom_range(63)); d1 = int'($urandom_range(63));
      r0 = int'($urandom_range(15)); r1 = int'($urandom_range(15));
      i0 = 1'($urandom_range(1));    i1 = 1'($urandom_range(1));
      wr(0, (int'(i0) << 7) | (int'($urandom_range(1)) << 6) | d0);
      wr(1, (int'(i1) << 7) | (int'($urandom_range(1)) << 6) | d1);
      wr(2, (r1 << 4) | r0);
      settle();
      total_high(t0, t1);
      check(t0 == exp_total(d0, r0, i0), "R8 R6 random ch0", t0, exp_total(d0, r0, i0));
      check(t1 == exp_total(d1, r1, i1), "R8 R6 random ch1", t1, exp_total(d1, r1, i1));
    end

    // R6: spare address has no effect
    wr(0, 33); wr(1, 8'h85); wr(2, 8'h6A);
    settle();
    total_high(t0, t1);
    sum0 = t0;
    wr(3, 8'hFF);
    settle();
    total_high(t0, t1);
    check(t0 == sum0 && t0 == exp_total(33, 10, 0), "R6 spare write ch0", t0, exp_total(33, 10, 0));
    check(t1 == exp_total(5, 6, 1), "R6 spare write ch1", t1, exp_total(5, 6, 1));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule